// File: doc/BRIEF.md
# Self-Repairing One-Hot Ring Sequencer

This block is a sixteen-position state register that holds a single circulating one. Each clock on which the advance input is high moves the one up by one position, and the top position wraps back to position 0. Software-free control logic elsewhere in the chip can use the sixteen state bits directly as phase strobes.

Two protections guard the register. A combinational legality checker flags any value that does not have exactly one bit set. It splits the vector into four-bit groups. Each group reports one of three outcomes: empty, single, or crowded. The vector is legal only if no group is crowded and exactly one group is single. A plain "exactly one" test per group, cascaded into a second "exactly one" test, would accept vectors such as 0xFEC1, so the three-way result is required.

The ring feedback also repairs itself. Positions 1 to 15 form a plain shift chain. Position 0 loads a one only when positions 0 to 14 are all clear. Any extra ones therefore shift out of the top, and an empty ring gets a fresh one. A corrupted ring returns to a legal one-hot state within at most sixteen advances, with no reset needed. The error flag is the legal flag inverted and delayed by one clock.

Top module: `ohseq_top`

## Requirements
- R1: While rst_n is low at a rising clock edge, the state loads 0x0001 (only bit 0 set) and err_o loads 0; after that edge legal_o is 1.
- R2: At a rising edge with rst_n high and adv_en low, the state is unchanged.
- R3: At a rising edge with rst_n high and adv_en high, a legal state with bit k set (k < 15) becomes bit k+1 set, and bit 15 set becomes bit 0 set.
- R4: legal_o is a combinational function of the current state, and it is 1 exactly when the state has one bit set, for all 65536 values.
- R5: Each four-bit group (bits 4g+3..4g) is classified as empty, single or crowded (two or more bits). The vector 0xFEC1 and the vector 0x0160 (one bit in group 2 and two bits in group 1) are illegal.
- R6: The all-zero vector is illegal.
- R7: err_o equals the inverse of legal_o as it was one clock earlier (reset excluded).
- R8: Starting from any 16-bit content, the register is legal after at most 16 advances. An all-zero content becomes 0x0001 after one advance.
- R9: Once the register holds a legal value, it stays legal on every later advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| adv_en | input | 1 | Advance the ring one position on this clock |
| state_o | output | 16 | Current one-hot state |
| legal_o | output | 1 | High when state_o has exactly one bit set |
| err_o | output | 1 | Registered inverse of legal_o |

## Verification
A corrupted state register shows at the ports straight away. legal_o drops in the same cycle that state_o leaves one-hot, and err_o rises one clock later. A repair rule that is too weak or too aggressive shows as a ring that is still illegal after sixteen advances, or as one that leaves a legal value. Because normal operation never produces an illegal value at the top, the bench drives the ring core with every possible preload and runs the checker over all 65536 vectors, comparing both against a bit count.

// File: rtl/ohseq_pkg.sv
// Package: shared types for the one-hot ring sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package ohseq_pkg;

    // Three-way occupancy of one bit group.
    typedef enum logic [1:0] {
        GC_NONE = 2'b00,
        GC_ONE  = 2'b01,
        GC_MANY = 2'b10
    } grp_cnt_e;

endpackage

// File: rtl/ohseq_group_count.sv
// Module: ohseq_group_count
// Classifies one group of bits as empty, single or crowded (two or more set).
// Assumes: GRP_W >= 1; purely combinational.
module ohseq_group_count
    import ohseq_pkg::*;
#(
    parameter int GRP_W = 4
) (
    input  logic [GRP_W-1:0] bits,
    output grp_cnt_e         cls
);

    logic seen_one;
    logic seen_many;

    // Saturating scan: remember a first one, then any second one.
    always_comb begin
        seen_one  = 1'b0;
        seen_many = 1'b0;
        for (int i = 0; i < GRP_W; i++) begin
            if (bits[i]) begin
                seen_many = seen_many | seen_one;
                seen_one  = 1'b1;
            end
        end
    end

    // Encode the scan result, crowded taking priority.
    always_comb begin
        if (seen_many)     cls = GC_MANY;
        else if (seen_one) cls = GC_ONE;
        else               cls = GC_NONE;
    end

    // R5: class agrees with an independent bit count of the group.
    always_comb begin
        if (!$isunknown(bits)) begin
            assert_group_class_R5: assert (
                (cls == GC_NONE && $countones(bits) == 0) ||
                (cls == GC_ONE  && $countones(bits) == 1) ||
                (cls == GC_MANY && $countones(bits) >= 2));
        end
    end

endmodule

// File: rtl/ohseq_legal_check.sv
// Module: ohseq_legal_check
// Exact one-hot test. It splits the vector into groups, classifies each three
// ways, and accepts only "no crowded group and exactly one single group".
// Assumes: VEC_W is a multiple of GRP_W; purely combinational.
module ohseq_legal_check
    import ohseq_pkg::*;
#(
    parameter int VEC_W = 16,
    parameter int GRP_W = 4
) (
    input  logic [VEC_W-1:0] vec,
    output logic             legal
);

    localparam int NGROUP = VEC_W / GRP_W;

    grp_cnt_e          cls   [NGROUP];
    logic [NGROUP-1:0] g_one;
    logic [NGROUP-1:0] g_many;
    logic              one_seen;
    logic              one_many;

    // One classifier per group.
    for (genvar g = 0; g < NGROUP; g++) begin : g_grp
        ohseq_group_count #(.GRP_W(GRP_W)) u_cnt (
            .bits (vec[g*GRP_W +: GRP_W]),
            .cls  (cls[g])
        );
        assign g_one[g]  = (cls[g] == GC_ONE);
        assign g_many[g] = (cls[g] == GC_MANY);
    end

    // Second tier: count single groups the same saturating way.
    always_comb begin
        one_seen = 1'b0;
        one_many = 1'b0;
        for (int g = 0; g < NGROUP; g++) begin
            if (g_one[g]) begin
                one_many = one_many | one_seen;
                one_seen = 1'b1;
            end
        end
    end

    // Combine: no crowded group, exactly one single group.
    always_comb legal = ~|g_many & one_seen & ~one_many;

    // R4, R6: verdict matches a whole-vector bit count.
    always_comb begin
        if (!$isunknown(vec)) begin
            assert_exact_R4: assert (legal == ($countones(vec) == 1));
        end
    end

endmodule

// File: rtl/ohseq_ring.sv
// Module: ohseq_ring
// Ring register with self-repairing feedback. Positions 1..N-1 shift up on
// each advance. Position 0 loads a one only when positions 0..N-2 are clear,
// so extra ones leave at the top and an empty ring is refilled.
// Assumes: N_STATES >= 2; synchronous active-low reset loads init_vec.
module ohseq_ring #(
    parameter int N_STATES = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv_en,
    input  logic [N_STATES-1:0] init_vec,
    output logic [N_STATES-1:0] state
);

    logic [N_STATES-1:0] state_q;
    logic [N_STATES-1:0] state_d;

    // Next value: shift chain plus guarded injection at position 0.
    always_comb begin
        state_d[N_STATES-1:1] = state_q[N_STATES-2:0];
        state_d[0]            = ~|state_q[N_STATES-2:0];
    end

    // State register: reset preload, advance, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      state_q <= init_vec;
        else if (adv_en) state_q <= state_d;
    end

    assign state = state_q;

    // R2: no advance, no change.
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(adv_en)) |-> $stable(state_q));

    // R9: a legal value stays legal across an advance.
    assert_stay_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(adv_en) && $onehot($past(state_q)))
        |-> $onehot(state_q));

    // R8: an empty ring is refilled at position 0 on the next advance.
    assert_refill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(adv_en) && ($past(state_q) == '0))
        |-> (state_q == N_STATES'(1)));

endmodule

// File: rtl/ohseq_top.sv
// Module: ohseq_top
// Sixteen-position one-hot sequencer with exact legality flag and a
// registered error flag. The ring repairs a corrupted value by itself.
// Assumes: N_STATES is a multiple of GRP_W; synchronous active-low reset.
module ohseq_top #(
    parameter int N_STATES = 16,
    parameter int GRP_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv_en,
    output logic [N_STATES-1:0] state_o,
    output logic                legal_o,
    output logic                err_o
);

    localparam logic [N_STATES-1:0] INIT_VEC = N_STATES'(1);
    localparam logic [N_STATES-1:0] TOP_VEC  = INIT_VEC << (N_STATES - 1);

    logic [N_STATES-1:0] ring_state;
    logic                chk_legal;

    // The state register with its repair feedback.
    ohseq_ring #(.N_STATES(N_STATES)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_en   (adv_en),
        .init_vec (INIT_VEC),
        .state    (ring_state)
    );

    // Exact one-hot checker on the live state.
    ohseq_legal_check #(.VEC_W(N_STATES), .GRP_W(GRP_W)) u_chk (
        .vec   (ring_state),
        .legal (chk_legal)
    );

    // Error flag: inverse of legality, one clock late.
    always_ff @(posedge clk) begin
        if (!rst_n) err_o <= 1'b0;
        else        err_o <= ~chk_legal;
    end

    assign state_o = ring_state;
    assign legal_o = chk_legal;

    // R1: first cycle out of reset shows the start position.
    assert_reset_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state_o == INIT_VEC && !err_o));

    // R3: top position wraps to position 0.
    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(adv_en) && $past(state_o) == TOP_VEC)
        |-> (state_o == INIT_VEC));

    // R3: a legal state below the top moves up one position.
    assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(adv_en) && $onehot($past(state_o)) &&
         !$past(state_o[N_STATES-1]))
        |-> (state_o == ($past(state_o) << 1)));

    // R7: error flag tracks the previous legal flag, inverted.
    assert_err_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (err_o == !$past(legal_o)));

endmodule

// File: tb/ohseq_top_test.sv
// Bench for ohseq_top. It runs directed and random advance patterns on the
// top, an exhaustive sweep of the legality checker, and an exhaustive repair
// sweep on sixteen ring cores that are preloaded through their reset value.
module ohseq_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 16;
    localparam int NCORE      = 16;
    localparam int WDOG       = 190000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         adv_en;
    logic [N-1:0] state_o;
    logic         legal_o;
    logic         err_o;

    logic [N-1:0] chk_vec;
    logic         chk_legal;

    logic         c_rst_n;
    logic         c_adv;
    logic [N-1:0] init_arr [NCORE];
    logic [N-1:0] st_arr   [NCORE];
    logic         seen_ok  [NCORE];
    logic         bad      [NCORE];

    int errors = 0;
    int checks = 0;
    int pos;

    always #(CLK_PERIOD/2) clk = ~clk;

    ohseq_top #(.N_STATES(N), .GRP_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .adv_en(adv_en),
        .state_o(state_o), .legal_o(legal_o), .err_o(err_o)
    );

    ohseq_legal_check #(.VEC_W(N), .GRP_W(4)) u_chk_only (
        .vec(chk_vec), .legal(chk_legal)
    );

    for (genvar g = 0; g < NCORE; g++) begin : g_core
        ohseq_ring #(.N_STATES(N)) u_core (
            .clk(clk), .rst_n(c_rst_n), .adv_en(c_adv),
            .init_vec(init_arr[g]), .state(st_arr[g])
        );
    end

    function automatic int popcnt(input logic [N-1:0] v);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(v[i]);
        return c;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (WDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n   = 1'b0;
        adv_en  = 1'b0;
        c_rst_n = 1'b0;
        c_adv   = 1'b0;
        chk_vec = '0;
        for (int g = 0; g < NCORE; g++) init_arr[g] = '0;

        // R1: reset state.
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(state_o == 16'h0001, "R1 reset state", 32'(state_o), 32'h1);
        check(legal_o == 1'b1, "R1 legal after reset", 32'(legal_o), 32'h1);
        check(err_o == 1'b0, "R1 err after reset", 32'(err_o), 32'h0);

        // R2: hold for twenty cycles with advance low.
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(state_o == 16'h0001, "R2 hold", 32'(state_o), 32'h1);
        end

        // R3: fifteen advances to the top, then a wrap to bit 0.
        adv_en = 1'b1;
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            check(state_o == (16'h0001 << (k % 16)), "R3 advance/wrap",
                  32'(state_o), 32'(16'h0001 << (k % 16)));
        end
        adv_en = 1'b0;

        // R3, R2, R7, R9: random advance pattern against a position model.
        pos = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            check(state_o == (16'h0001 << pos), "R3 random position",
                  32'(state_o), 32'(16'h0001 << pos));
            check(legal_o && !err_o, "R7 flags in normal run",
                  {30'd0, legal_o, err_o}, 32'h2);
            adv_en = ($urandom % 3) != 0;
            if (adv_en) pos = (pos + 1) % N;
        end

        // R1: reset in the middle of a run.
        @(negedge clk);
        rst_n = 1'b0; adv_en = 1'b1;
        @(negedge clk);
        rst_n = 1'b1; adv_en = 1'b0;
        check(state_o == 16'h0001, "R1 mid-run reset", 32'(state_o), 32'h1);

        // R5, R6, R4: named corner vectors on the checker.
        chk_vec = 16'hFEC1; #1;
        check(chk_legal == 1'b0, "R5 0xFEC1 illegal", 32'(chk_legal), 32'h0);
        chk_vec = 16'h0160; #1;
        check(chk_legal == 1'b0, "R5 0x0160 illegal", 32'(chk_legal), 32'h0);
        chk_vec = 16'h0000; #1;
        check(chk_legal == 1'b0, "R6 zero illegal", 32'(chk_legal), 32'h0);
        chk_vec = 16'h8000; #1;
        check(chk_legal == 1'b1, "R4 0x8000 legal", 32'(chk_legal), 32'h1);

        // R4: exhaustive sweep of the checker against a bit count.
        for (int v = 0; v < 65536; v++) begin
            chk_vec = 16'(v); #1;
            check(chk_legal == (popcnt(16'(v)) == 1), "R4 exhaustive",
                  32'(chk_legal), 32'(popcnt(16'(v)) == 1));
        end

        // R8, R9: every preload repairs within 16 advances and stays legal.
        for (int idx = 0; idx < 65536 / NCORE; idx++) begin
            @(negedge clk);
            for (int g = 0; g < NCORE; g++) begin
                init_arr[g] = 16'(g * (65536 / NCORE) + idx);
                seen_ok[g]  = 1'b0;
                bad[g]      = 1'b0;
            end
            c_rst_n = 1'b0; c_adv = 1'b0;
            @(negedge clk);
            for (int g = 0; g < NCORE; g++)
                if (st_arr[g] != init_arr[g]) bad[g] = 1'b1;
            c_rst_n = 1'b1; c_adv = 1'b1;
            for (int k = 1; k <= 17; k++) begin
                @(negedge clk);
                for (int g = 0; g < NCORE; g++) begin
                    if (popcnt(st_arr[g]) == 1) seen_ok[g] = 1'b1;
                    else if (seen_ok[g] || k >= 16) bad[g] = 1'b1;
                    if (k == 1 && init_arr[g] == '0 && st_arr[g] != 16'h0001)
                        bad[g] = 1'b1;
                end
            end
            c_adv = 1'b0;
            for (int g = 0; g < NCORE; g++)
                check(!bad[g], "R8/R9 repair from preload",
                      32'(st_arr[g]), 32'(init_arr[g]));
        end

        finish_run();
    end

endmodule